// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and its memories. For each access it decides which storage the cycle reaches: the 64 KiB RAM, the overlay ROM, or one of two copies of the I/O page. One copy holds the values written by the CPU. The other holds the values a peripheral presents for reading. The decision depends on the access direction, the address, and the two low bits of a banking register that lives at RAM address 1. The block keeps its own shadow of that register.

Reads and writes follow different maps. ROM overlays RAM on reads only, so a write under ROM always reaches RAM. On writes, the I/O page folds mirrored sound-chip locations above the 32-byte register block back onto that block. Two programmable secondary sound windows are exempt from this folding, and so is a digital-playback range. On reads, the sound-chip registers return the write-side copy, which is the last value written.

The outputs are a 2-bit target code and a 16-bit effective address. Both are a combinational function of the access and the registered banking value. There is no path from the write data to either output.

Top module: `mmap_decoder`

## Requirements
- R1: A read below 0xA000 selects RAM (target code 00) with the effective address equal to the access address, for every banking value.
- R2: A read in 0xD000–0xDFFF selects the I/O read copy (code 11) when banking bits [1:0] are not 00, and selects RAM when they are 00. R4 makes an exception to this.
- R3: A read in 0xA000–0xBFFF selects ROM (code 01) only when banking bits [1:0] are 11. A read at 0xE000 or above selects ROM whenever banking bit 1 is 1. Every other read in 0xA000–0xFFFF, including all of 0xC000–0xCFFF, selects RAM.
- R4: A read in 0xD400–0xD418 selects the I/O write copy (code 10) at the unchanged address while the I/O page is mapped.
- R5: A write below 0xD000 or at 0xE000 and above selects RAM at the unchanged address, for every banking value, including addresses that ROM overlays on reads.
- R6: A write in 0xD000–0xDFFF selects the I/O write copy (code 10) when banking bits [1:0] are not 00, and selects RAM at the unchanged address when they are 00.
- R7: A write to 0xD420–0xD7FF while the I/O page is mapped goes to 0xD400 plus address bits [4:0], unless R8 or R9 exempts it. Writes to other I/O addresses keep their address.
- R8: A write that falls inside a secondary window keeps its own address. Each window is 32 bytes starting at its base. A base of zero disables that window.
- R9: While digital-playback mode is set, a write in 0xD418–0xD4FF keeps its own address.
- R10: Reset loads the banking register with 0x37. This maps both ROM areas and the I/O page.
- R11: A valid write to address 1 loads the write data into the banking register on that clock edge. A read of address 1, or a write with the valid flag low, leaves the register unchanged. A new value governs decoding from the following access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, qualifies banking-register updates |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | 16 | CPU address |
| acc_wdata | input | 8 | CPU write data (used only for the banking register) |
| sec_base | input | 32 | Two secondary window bases, window 0 in bits [15:0] |
| digi_mode | input | 1 | Digital-playback mode, exempts 0xD418–0xD4FF from folding |
| tgt | output | 2 | Target code: 00 RAM, 01 ROM, 10 I/O write copy, 11 I/O read copy |
| eff_addr | output | 16 | Effective address within the selected target |

## Verification
Each address region is tried under all four banking values. Across that matrix, a read at 0xA000, 0xC000, 0xD000 and 0xE000 tells the ROM condition that needs both bits apart from the one that needs only bit 1, and both apart from the I/O mapping. Write probes at the edges of the fold range (0xD41F, 0xD420, 0xD7FF, 0xD800) show where folding starts and stops. Probes at the inside and outside edges of each secondary window, and of the digital-playback range, tell an exemption apart from ordinary folding. Banking changes are made through real writes to address 1, next to reads of address 1 and writes with the strobe low, so that a correct update can be distinguished from a stray one.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        TGT_RAM = 2'b00,
        TGT_ROM = 2'b01,
        TGT_IOW = 2'b10,
        TGT_IOR = 2'b11
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
    } route_t;

    // Region boundaries
    localparam logic [ADDR_W-1:0] LOW_ROM_BASE = 16'hA000;
    localparam logic [ADDR_W-1:0] MID_RAM_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] IO_BASE      = 16'hD000;
    localparam logic [ADDR_W-1:0] HI_ROM_BASE  = 16'hE000;

    // Sound-chip register block and its mirror zone
    localparam logic [ADDR_W-1:0] SND_BASE     = 16'hD400;
    localparam logic [ADDR_W-1:0] SND_RD_LAST  = 16'hD418;
    localparam logic [ADDR_W-1:0] MIRROR_LO    = 16'hD420;
    localparam logic [ADDR_W-1:0] MIRROR_HI    = 16'hD7FF;
    localparam int                SND_SPAN     = 32;
    localparam int                FOLD_W       = $clog2(SND_SPAN);

    // Digital-playback exempt range
    localparam logic [ADDR_W-1:0] DIGI_LO      = 16'hD418;
    localparam logic [ADDR_W-1:0] DIGI_HI      = 16'hD4FF;

    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic io_region(input logic [ADDR_W-1:0] a);
        return (a >= IO_BASE) && (a < HI_ROM_BASE);
    endfunction

    function automatic logic [ADDR_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
        return SND_BASE | {{(ADDR_W-FOLD_W){1'b0}}, a[FOLD_W-1:0]};
    endfunction

endpackage

// File: rtl/mmap_bank_reg.sv
module mmap_bank_reg
    import mmap_pkg::*;
#(
    parameter logic [DATA_W-1:0] BANK_INIT = 8'h37,
    parameter logic [ADDR_W-1:0] BANK_LOC  = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] bank_q
);

    logic hit;

    always_comb begin
        hit = acc_valid && acc_write && (acc_addr == BANK_LOC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= BANK_INIT;
        end else if (hit) begin
            bank_q <= acc_wdata;
        end
    end

endmodule

// File: rtl/mmap_read_dec.sv
module mmap_read_dec
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bank,
    output route_t            route
);

    logic io_on;
    logic low_rom_on;
    logic hi_rom_on;

    always_comb begin
        io_on      = (bank != 2'b00);
        low_rom_on = (bank == 2'b11);
        hi_rom_on  = bank[1];

        route.addr = addr;
        route.tgt  = TGT_RAM;

        if (addr >= LOW_ROM_BASE) begin
            if (io_region(addr)) begin
                if (io_on) begin
                    // sound registers read back the write-side copy
                    route.tgt = in_span(addr, SND_BASE, SND_RD_LAST) ? TGT_IOW : TGT_IOR;
                end
            end else if (addr < MID_RAM_BASE) begin
                if (low_rom_on) route.tgt = TGT_ROM;
            end else if (addr >= HI_ROM_BASE) begin
                if (hi_rom_on) route.tgt = TGT_ROM;
            end
        end
    end

endmodule

// File: rtl/mmap_write_dec.sv
module mmap_write_dec
    import mmap_pkg::*;
#(
    parameter int NUM_SEC  = 2,
    parameter int WIN_SPAN = 32
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [1:0]                bank,
    input  logic [NUM_SEC*ADDR_W-1:0] sec_base,
    input  logic                      digi_mode,
    output route_t                    route
);

    localparam int EXT_W = ADDR_W + 1;

    logic [NUM_SEC-1:0] win_hit;
    logic               digi_hit;
    logic               exempt;
    logic               mirror;

    // One comparator pair per secondary window
    for (genvar w = 0; w < NUM_SEC; w++) begin : g_win
        logic [ADDR_W-1:0] base_w;
        logic [EXT_W-1:0]  lo_ext;
        logic [EXT_W-1:0]  hi_ext;
        logic [EXT_W-1:0]  a_ext;
        always_comb begin
            base_w     = sec_base[w*ADDR_W +: ADDR_W];
            lo_ext     = {1'b0, base_w};
            hi_ext     = lo_ext + EXT_W'(WIN_SPAN);
            a_ext      = {1'b0, addr};
            win_hit[w] = (base_w != '0) && (a_ext >= lo_ext) && (a_ext < hi_ext);
        end
    end

    always_comb begin
        digi_hit = digi_mode && in_span(addr, DIGI_LO, DIGI_HI);
        exempt   = (|win_hit) || digi_hit;
        mirror   = in_span(addr, MIRROR_LO, MIRROR_HI);

        route.addr = addr;
        route.tgt  = TGT_RAM;

        if (io_region(addr) && (bank != 2'b00)) begin
            route.tgt = TGT_IOW;
            if (mirror && !exempt) begin
                route.addr = fold_addr(addr);
            end
        end
    end

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int                NUM_SEC   = 2,
    parameter int                WIN_SPAN  = 32,
    parameter logic [DATA_W-1:0] BANK_INIT = 8'h37,
    parameter logic [ADDR_W-1:0] BANK_LOC  = 16'h0001
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [DATA_W-1:0]         acc_wdata,
    input  logic [NUM_SEC*ADDR_W-1:0] sec_base,
    input  logic                      digi_mode,
    output logic [1:0]                tgt,
    output logic [ADDR_W-1:0]         eff_addr
);

    logic [DATA_W-1:0] bank_q;
    route_t            rd_route;
    route_t            wr_route;
    route_t            sel_route;

    mmap_bank_reg #(
        .BANK_INIT (BANK_INIT),
        .BANK_LOC  (BANK_LOC)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .bank_q    (bank_q)
    );

    mmap_read_dec u_rd (
        .addr  (acc_addr),
        .bank  (bank_q[1:0]),
        .route (rd_route)
    );

    mmap_write_dec #(
        .NUM_SEC  (NUM_SEC),
        .WIN_SPAN (WIN_SPAN)
    ) u_wr (
        .addr      (acc_addr),
        .bank      (bank_q[1:0]),
        .sec_base  (sec_base),
        .digi_mode (digi_mode),
        .route     (wr_route)
    );

    always_comb begin
        sel_route = acc_write ? wr_route : rd_route;
        tgt       = sel_route.tgt;
        eff_addr  = sel_route.addr;
    end

endmodule

module mmap_decoder_chk
    import mmap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [1:0]        tgt,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [DATA_W-1:0] bank_q
);

    a_r1_low_read_ram: assert property (@(posedge clk) disable iff (rst)
        (!acc_write && acc_addr < 16'hA000) |-> (tgt == 2'b00 && eff_addr == acc_addr));

    a_r2_io_unmapped_ram: assert property (@(posedge clk) disable iff (rst)
        (!acc_write && acc_addr >= 16'hD000 && acc_addr < 16'hE000 && bank_q[1:0] == 2'b00)
        |-> (tgt == 2'b00));

    a_r4_wcopy_read_window: assert property (@(posedge clk) disable iff (rst)
        (!acc_write && tgt == 2'b10) |-> (acc_addr >= 16'hD400 && acc_addr <= 16'hD418));

    a_r5_write_outside_io_ram: assert property (@(posedge clk) disable iff (rst)
        (acc_write && (acc_addr < 16'hD000 || acc_addr >= 16'hE000))
        |-> (tgt == 2'b00 && eff_addr == acc_addr));

    a_r7_fold_target: assert property (@(posedge clk) disable iff (rst)
        (acc_write && eff_addr != acc_addr)
        |-> (tgt == 2'b10 && eff_addr[15:5] == 11'h6A0 && eff_addr[4:0] == acc_addr[4:0]));

    a_r10_reset_value: assert property (@(posedge clk)
        rst |=> (bank_q == 8'h37));

    a_r11_bank_load: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr == 16'h0001) |=> (bank_q == $past(acc_wdata)));

    a_r11_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && acc_addr == 16'h0001) |=> $stable(bank_q));

endmodule

bind mmap_decoder mmap_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .tgt       (tgt),
    .eff_addr  (eff_addr),
    .bank_q    (bank_q)
);

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = 16'h0000;
    logic [7:0]  acc_wdata = 8'h00;
    logic [31:0] sec_base = 32'h0;
    logic        digi_mode = 1'b0;
    logic [1:0]  tgt;
    logic [15:0] eff_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmap_decoder uut (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .sec_base  (sec_base),
        .digi_mode (digi_mode),
        .tgt       (tgt),
        .eff_addr  (eff_addr)
    );

    // Expected read target from R1..R4
    function automatic logic [1:0] exp_rd(input logic [15:0] a, input logic [1:0] b);
        if (a < 16'hA000) return 2'b00;
        if (a >= 16'hD000 && a < 16'hE000) begin
            if (b == 2'b00) return 2'b00;
            return (a <= 16'hD418 && a >= 16'hD400) ? 2'b10 : 2'b11;
        end
        if (a < 16'hC000) return (b == 2'b11) ? 2'b01 : 2'b00;
        if (a >= 16'hE000) return b[1] ? 2'b01 : 2'b00;
        return 2'b00;
    endfunction

    task automatic check(input string req, input logic [1:0] et, input logic [15:0] ea);
        checks++;
        if (tgt !== et || eff_addr !== ea) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0b: tgt=%b eff=%h expected tgt=%b eff=%h",
                     req, acc_addr, acc_write, tgt, eff_addr, et, ea);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input string req,
                          input logic [1:0] et, input logic [15:0] ea);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_addr  = a;
        acc_wdata = 8'h00;
        if (wr && a == 16'h0001) acc_valid = 1'b0;
        #5;
        check(req, et, ea);
        acc_valid = 1'b0;
    endtask

    task automatic set_bank(input logic [7:0] v);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = 1'b1;
        acc_addr  = 16'h0001;
        acc_wdata = v;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic t_reset;
        access(1'b0, 16'hA000, "R10", 2'b01, 16'hA000);
        access(1'b0, 16'hE000, "R10", 2'b01, 16'hE000);
        access(1'b0, 16'hD020, "R10", 2'b11, 16'hD020);
    endtask

    task automatic t_read_matrix;
        logic [15:0] probes [8];
        probes = '{16'h0000, 16'h9FFF, 16'hA000, 16'hBFFF,
                   16'hC000, 16'hD000, 16'hE000, 16'hFFFF};
        for (int b = 0; b < 4; b++) begin
            set_bank(8'h30 | 8'(b));
            for (int p = 0; p < 8; p++) begin
                access(1'b0, probes[p], (p < 2) ? "R1" : (p == 5) ? "R2" : "R3",
                       exp_rd(probes[p], 2'(b)), probes[p]);
            end
        end
    endtask

    task automatic t_sound_read;
        set_bank(8'h35);
        access(1'b0, 16'hD400, "R4", 2'b10, 16'hD400);
        access(1'b0, 16'hD418, "R4", 2'b10, 16'hD418);
        access(1'b0, 16'hD419, "R4", 2'b11, 16'hD419);
        access(1'b0, 16'hD3FF, "R4", 2'b11, 16'hD3FF);
    endtask

    task automatic t_write_map;
        set_bank(8'h37);
        access(1'b1, 16'hA000, "R5", 2'b00, 16'hA000);
        access(1'b1, 16'hFFFF, "R5", 2'b00, 16'hFFFF);
        access(1'b1, 16'hCFFF, "R5", 2'b00, 16'hCFFF);
        access(1'b1, 16'hD000, "R6", 2'b10, 16'hD000);
        set_bank(8'h30);
        access(1'b1, 16'hD000, "R6", 2'b00, 16'hD000);
        access(1'b1, 16'hD420, "R6", 2'b00, 16'hD420);
        set_bank(8'h32);
        access(1'b1, 16'hDFFF, "R6", 2'b10, 16'hDFFF);
    endtask

    task automatic t_fold;
        set_bank(8'h35);
        access(1'b1, 16'hD41F, "R7", 2'b10, 16'hD41F);
        access(1'b1, 16'hD420, "R7", 2'b10, 16'hD400);
        access(1'b1, 16'hD537, "R7", 2'b10, 16'hD417);
        access(1'b1, 16'hD7FF, "R7", 2'b10, 16'hD41F);
        access(1'b1, 16'hD800, "R7", 2'b10, 16'hD800);
    endtask

    task automatic t_windows;
        set_bank(8'h37);
        sec_base = {16'hD600, 16'hD500};
        access(1'b1, 16'hD4FF, "R8", 2'b10, 16'hD41F);
        access(1'b1, 16'hD500, "R8", 2'b10, 16'hD500);
        access(1'b1, 16'hD51F, "R8", 2'b10, 16'hD51F);
        access(1'b1, 16'hD520, "R8", 2'b10, 16'hD400);
        access(1'b1, 16'hD605, "R8", 2'b10, 16'hD605);
        access(1'b1, 16'hD620, "R8", 2'b10, 16'hD400);
        sec_base = 32'h0;
        access(1'b1, 16'hD500, "R8", 2'b10, 16'hD400);
    endtask

    task automatic t_digi;
        digi_mode = 1'b1;
        access(1'b1, 16'hD420, "R9", 2'b10, 16'hD420);
        access(1'b1, 16'hD4FF, "R9", 2'b10, 16'hD4FF);
        access(1'b1, 16'hD500, "R9", 2'b10, 16'hD400);
        digi_mode = 1'b0;
        access(1'b1, 16'hD4FF, "R9", 2'b10, 16'hD41F);
    endtask

    task automatic t_bank_update;
        set_bank(8'h37);
        // read of address 1 must not load the register
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'h0001; acc_wdata = 8'h30;
        @(negedge clk);
        acc_valid = 1'b0;
        access(1'b0, 16'hA000, "R11", 2'b01, 16'hA000);
        // write with strobe low must not load it either
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 16'h0001; acc_wdata = 8'h30;
        @(negedge clk);
        acc_write = 1'b0;
        access(1'b0, 16'hE000, "R11", 2'b01, 16'hE000);
        // valid write: new value rules the next access
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h0001; acc_wdata = 8'h36;
        #5;
        check("R11", 2'b00, 16'h0001);
        @(negedge clk);
        acc_valid = 1'b0;
        access(1'b0, 16'hA000, "R11", 2'b00, 16'hA000);
        access(1'b0, 16'hE000, "R11", 2'b01, 16'hE000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_matrix();
        t_sound_read();
        t_write_map();
        t_fold();
        t_windows();
        t_digi();
        t_bank_update();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule